// File: doc/BRIEF.md
# Lone Serial Character Detector

This block sits beside a UART receiver and watches the same raw receive line. It reports that a single isolated character has arrived without waiting for a FIFO threshold or a long receive timeout. The line has to rest high for two character times before the detector is ready. A falling edge seen while it is ready is taken as a start bit, and a frame timer then counts bit ticks. When the timer expires, the detector looks at the line once. A high line means no second character followed, so a sticky flag is raised.

The bit ticks come from outside the block as a one-cycle pulse per bit period. A small margin input sets how many extra bit periods the timer runs past the ten-bit frame: a start bit, eight data bits and a stop bit. The detector clamps the total timer length so that it always decides within 15 bit periods of the start edge. The flag stays set until software or a neighbouring block pulses the clear input. Reading the received byte is left to the UART.

Top module: `lone_char_detect`

## Requirements
- R1: After reset the flag is 0 and the line synchroniser holds the idle (high) level.
- R2: The detector becomes ready only after 20 consecutive bit ticks with the synchronised line high. A start edge after only 19 such ticks produces no flag.
- R3: A falling edge on the line while the detector is not ready starts nothing, and the flag stays 0 through that character.
- R4: The line is sampled on the L-th bit tick after the start edge, where L = 10 + the margin. The flag is 0 up to and including the tick before that one.
- R5: If the synchronised line is high at the sample tick, the flag rises on that clock edge. If the line is low, the flag stays 0.
- R6: A margin above 5 is treated as 5, so L never exceeds 15.
- R7: The margin is captured at the start edge. A change to the margin input during a frame does not move that frame's sample tick.
- R8: The flag holds its value until the clear input is high for a clock cycle, and it reads 0 on the following cycle.
- R9: After every decision, whether a flag or a discard, the detector needs another 20 high bit ticks before it is ready again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_line | input | 1 | Raw serial receive line, asynchronous to clk |
| bit_tick | input | 1 | One-cycle pulse per bit period |
| margin_ticks | input | MW (3) | Extra bit periods added after the ten-bit frame |
| flag_clr | input | 1 | Clears the flag |
| single_flag | output | 1 | Set when a lone character has been detected |

## Verification
The bench sweeps every margin value from 0 to 7. It pairs each margin with a lone character and with a second character following after gaps of 0 to 3 bit periods. The expected flag is worked out from the line value during the bit interval just before the sample tick. A detector whose timer is one tick off would therefore raise the flag when a following start bit or data bit is low, or miss it when that bit is high. A missing clamp would push the decision past 15 ticks for margins 6 and 7.

The bench also targets the arming boundary: 19 idle ticks must not arm the detector, while 20 must. The same boundary is tested for re-arming after a flag. A margin change in the middle of a frame is applied to catch a design that reads the margin live instead of latching it at the start edge.

// File: rtl/lone_char_detect.sv
module lone_char_detect #(
  parameter int CHAR_BITS  = 10,
  parameter int IDLE_CHARS = 2,
  parameter int DEADLINE   = 15,
  parameter int MW         = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_line,
  input  logic          bit_tick,
  input  logic [MW-1:0] margin_ticks,
  input  logic          flag_clr,
  output logic          single_flag
);
  localparam int IDLE_LIMIT = IDLE_CHARS * CHAR_BITS;
  localparam int IW         = $clog2(IDLE_LIMIT + 1);
  localparam int TW         = $clog2(DEADLINE + 1);
  localparam int MAX_MARGIN = DEADLINE - CHAR_BITS;

  typedef enum logic [1:0] {S_WAIT = 2'd0, S_ARMED = 2'd1, S_TIME = 2'd2} st_t;

  st_t           state;
  logic [2:0]    sync;
  logic [IW-1:0] idle_cnt;
  logic [TW-1:0] timer;
  logic [TW-1:0] lim;
  logic [TW-1:0] eff_lim;
  logic          rx_s;
  logic          fall;
  logic          expire;
  logic          set_flag;

  assign rx_s     = sync[1];
  assign fall     = sync[2] & ~sync[1];
  assign eff_lim  = (int'(margin_ticks) > MAX_MARGIN) ? TW'(DEADLINE)
                                                      : TW'(CHAR_BITS + int'(margin_ticks));
  assign expire   = (state == S_TIME) && bit_tick && (timer == lim - TW'(1));
  assign set_flag = expire && rx_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync <= '1;
    else        sync <= {sync[1:0], rx_line};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_WAIT;
      idle_cnt <= '0;
      timer    <= '0;
      lim      <= TW'(CHAR_BITS);
    end else begin
      case (state)
        S_WAIT: begin
          if (!rx_s) idle_cnt <= '0;
          else if (bit_tick) begin
            if (idle_cnt == IW'(IDLE_LIMIT - 1)) begin
              state    <= S_ARMED;
              idle_cnt <= '0;
            end else begin
              idle_cnt <= idle_cnt + IW'(1);
            end
          end
        end
        S_ARMED: begin
          if (fall) begin
            state <= S_TIME;
            timer <= '0;
            lim   <= eff_lim;
          end
        end
        S_TIME: begin
          if (expire) begin
            state    <= S_WAIT;
            idle_cnt <= '0;
          end else if (bit_tick) begin
            timer <= timer + TW'(1);
          end
        end
        default: state <= S_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) single_flag <= 1'b0;
    else        single_flag <= set_flag | (single_flag & ~flag_clr);
  end
endmodule

// File: rtl/lone_char_detect_chk.sv
module lone_char_detect_chk #(
  parameter int IW         = 5,
  parameter int TW         = 4,
  parameter int IDLE_LIMIT = 20,
  parameter int DEADLINE   = 15
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bit_tick,
  input logic          rx_s,
  input logic          flag,
  input logic          flag_clr,
  input logic [1:0]    state,
  input logic [IW-1:0] idle_cnt,
  input logic [TW-1:0] timer
);
  assert_arm_threshold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd1 && $past(state) != 2'd1) |->
      ($past(idle_cnt) == IW'(IDLE_LIMIT - 1) && $past(bit_tick)));

  assert_set_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(bit_tick) && $past(state) == 2'd2));

  assert_set_line_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(rx_s));

  assert_timer_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == 2'd2) |-> (int'(timer) < DEADLINE));

  assert_flag_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  assert_flag_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr));
endmodule

bind lone_char_detect lone_char_detect_chk #(
  .IW(IW), .TW(TW), .IDLE_LIMIT(IDLE_LIMIT), .DEADLINE(DEADLINE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_s(rx_s),
  .flag(single_flag), .flag_clr(flag_clr), .state(state),
  .idle_cnt(idle_cnt), .timer(timer)
);

// File: tb/test_lone_char_detect.sv
module test_lone_char_detect;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_line = 1'b1;
  logic [2:0] margin_ticks = 3'd2;
  logic       flag_clr = 1'b0;
  logic       single_flag;
  logic [2:0] tcnt = '0;
  logic       bit_tick;
  int         total = 0;
  int         bad = 0;

  always #10 clk = ~clk;

  always_ff @(posedge clk) tcnt <= tcnt + 3'd1;
  assign bit_tick = (tcnt == 3'd7);

  lone_char_detect i_lone_char_detect (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .bit_tick(bit_tick),
    .margin_ticks(margin_ticks), .flag_clr(flag_clr), .single_flag(single_flag)
  );

  task automatic chk(input logic got, input logic exp, input string rq);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", rq, got, exp, $time);
    end
  endtask

  task automatic next_tick();
    do @(negedge clk); while (!bit_tick);
    @(negedge clk);
  endtask

  function automatic logic sbit(input int i, input logic [7:0] b1, input bit two,
                                input int g, input logic [7:0] b2);
    int j;
    if (i == 0) return 1'b0;
    if (i <= 8) return b1[i-1];
    if (i == 9 || !two) return 1'b1;
    j = i - 10 - g;
    if (j < 0) return 1'b1;
    if (j == 0) return 1'b0;
    if (j <= 8) return b2[j-1];
    return 1'b1;
  endfunction

  task automatic prefix(input int n);
    rx_line = 1'b0;
    next_tick();
    next_tick();
    rx_line = 1'b1;
    for (int k = 0; k < n; k++) next_tick();
  endtask

  task automatic frame_check(input int m, input int m_late, input logic [7:0] b1,
                             input bit two, input int g, input logic [7:0] b2,
                             input bit armed, input bit full, input string rq);
    int   L;
    logic exp;
    L = 10 + ((m > 5) ? 5 : m);
    exp = armed ? sbit(L - 1, b1, two, g, b2) : 1'b0;
    margin_ticks = 3'(m);
    for (int i = 0; i < (full ? 25 : L); i++) begin
      rx_line = sbit(i, b1, two, g, b2);
      if (i == 1) margin_ticks = 3'(m_late);
      next_tick();
      if (i + 1 == L - 1) chk(single_flag, 1'b0, "R4 early");
      if (i + 1 == L) chk(single_flag, exp, rq);
    end
  endtask

  task automatic clear_flag();
    @(negedge clk) flag_clr = 1'b1;
    @(negedge clk) flag_clr = 1'b0;
    chk(single_flag, 1'b0, "R8 clear");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(single_flag, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(single_flag, 1'b0, "R1 after reset");

    for (int m = 0; m < 8; m++) begin
      for (int s = 0; s < 5; s++) begin
        logic [7:0] b1;
        logic [7:0] b2;
        b1 = 8'h5A ^ 8'(m * 17);
        b2 = s[0] ? 8'h35 : 8'hC2;
        prefix(20);
        frame_check(m, m, b1, s != 0, s - 1, b2, 1'b1, 1'b1, (m > 5) ? "R6" : "R5");
        if (single_flag) begin
          next_tick();
          next_tick();
          chk(single_flag, 1'b1, "R8 hold");
        end
        clear_flag();
      end
    end

    prefix(19);
    frame_check(2, 2, 8'h81, 1'b0, 0, 8'h00, 1'b0, 1'b1, "R2 19 ticks");
    clear_flag();
    prefix(20);
    frame_check(2, 2, 8'h81, 1'b0, 0, 8'h00, 1'b1, 1'b1, "R2 20 ticks");
    clear_flag();
    prefix(5);
    frame_check(1, 1, 8'h00, 1'b0, 0, 8'h00, 1'b0, 1'b1, "R3 not armed");
    clear_flag();

    prefix(20);
    frame_check(1, 5, 8'hF0, 1'b0, 0, 8'h00, 1'b1, 1'b0, "R7 late margin");
    clear_flag();
    prefix(20);
    frame_check(4, 0, 8'h0F, 1'b1, 3, 8'h00, 1'b1, 1'b1, "R7 late margin low");
    clear_flag();

    prefix(20);
    frame_check(2, 2, 8'h3C, 1'b0, 0, 8'h00, 1'b1, 1'b0, "R5 before rearm");
    clear_flag();
    for (int k = 0; k < 19; k++) next_tick();
    frame_check(2, 2, 8'h3C, 1'b0, 0, 8'h00, 1'b0, 1'b0, "R9 19 ticks");
    clear_flag();
    prefix(20);
    frame_check(3, 3, 8'hC3, 1'b0, 0, 8'h00, 1'b1, 1'b0, "R5 before rearm");
    clear_flag();
    for (int k = 0; k < 20; k++) next_tick();
    frame_check(3, 3, 8'hC3, 1'b0, 0, 8'h00, 1'b1, 1'b0, "R9 20 ticks");
    clear_flag();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule